// File: doc/BRIEF.md
# Floating-Point Coprocessor Issue Scoreboard

This block sits between the decode stage and the execution pipes of a floating-point coprocessor that has three pipes: a multiply-accumulate (MAC) pipe, a divide/square-root (DS) pipe and a load/store/transfer (LS) pipe. Decode offers one operation per cycle on a valid/ready handshake. Each operation has a class code, two optional source register indices and one optional destination register index.

The scoreboard keeps a busy countdown for the first stage of each pipe and a ready countdown for each architectural register. It lowers `in_ready` while the offered operation would collide with a pipe that is still busy, would read a register whose result is not ready, or would overwrite a register that still has a pending write. When the handshake completes, all the counters are loaded. One cycle later a registered issue pulse, together with the class and destination of the accepted operation, tells the pipes to start. Read-after-write dependences and write ordering are enforced. A later write to a register that an earlier operation reads is never stalled.

Top module: `fp_issue_sb`

## Requirements
- R1: After synchronous reset, every counter is zero, `issue_o` is low and `in_ready` is high for any offered operation.
- R2: Class codes are 0 fast, 1 arithmetic/convert, 2 double multiply, 3 single divide/sqrt, 4 double divide/sqrt, 5 load/store/transfer and 6 flag transfer. A consumer that reads the destination of a producer is accepted exactly L cycles after the producer. L is 4, 8, 9, 19, 33 and 4 for codes 0 to 5.
- R3: The MAC stage is held for 1 cycle by codes 0, 1 and 4, and for 2 cycles by code 2. An independent MAC user issues 1 or 2 cycles after such an operation.
- R4: The DS pipe is held for 15 cycles by code 3 and for 29 cycles by code 4. An independent DS user waits that long.
- R5: The LS pipe is held for 1 cycle by code 5 and for 3 cycles by code 6.
- R6: A code 6 operation is not accepted in any cycle in which the MAC or DS counter is nonzero.
- R7: An operation whose destination still has a pending write stalls until that count reaches zero.
- R8: Writing a register that an in-flight operation reads causes no stall.
- R9: A source or destination field whose enable bit is low is ignored by the hazard check.
- R10: `issue_o` rises in the cycle after each handshake, for one cycle per operation. `issue_class_o` and `issue_dst_o` carry the class and destination of the accepted operation.
- R11: `in_ready` depends only on the counters and the offered fields, not on `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_class | input | 3 | Operation class code |
| in_src0 | input | IW | First source register |
| in_src0_en | input | 1 | First source is used |
| in_src1 | input | IW | Second source register |
| in_src1_en | input | 1 | Second source is used |
| in_dst | input | IW | Destination register |
| in_dst_en | input | 1 | Destination is written |
| issue_o | output | 1 | Registered issue pulse |
| issue_class_o | output | 3 | Class of the issued operation |
| issue_dst_o | output | IW | Destination of the issued operation |

## Verification
The hardest case to reach from the ports is a flag transfer that is blocked only by a long-running divide. The DS counter can be nonzero while the MAC pipe and every register are idle, so the stall has no other cause. The stimulus issues a divide of each precision with an unrelated destination and offers the flag transfer in the very next cycle. Its acceptance cycle must match the full divide occupancy.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

  typedef enum logic [2:0] {
    OP_FAST  = 3'd0,
    OP_ARITH = 3'd1,
    OP_DMUL  = 3'd2,
    OP_SDIV  = 3'd3,
    OP_DDIV  = 3'd4,
    OP_XFER  = 3'd5,
    OP_FLAG  = 3'd6,
    OP_RSVD  = 3'd7
  } op_class_e;

  localparam int CostW = 8;

  // Result latency and first-stage occupancy per pipe, in cycles.
  typedef struct packed {
    logic [CostW-1:0] lat;
    logic [CostW-1:0] mac_occ;
    logic [CostW-1:0] ds_occ;
    logic [CostW-1:0] ls_occ;
    logic             quiet;   // needs MAC and DS idle
  } op_cost_t;

  function automatic op_cost_t cost_of(input logic [2:0] c);
    op_cost_t r;
    r = '{lat: 8'd1, mac_occ: 8'd0, ds_occ: 8'd0, ls_occ: 8'd0, quiet: 1'b0};
    case (c)
      3'd0: begin r.lat = 8'd4;  r.mac_occ = 8'd1; end
      3'd1: begin r.lat = 8'd8;  r.mac_occ = 8'd1; end
      3'd2: begin r.lat = 8'd9;  r.mac_occ = 8'd2; end
      3'd3: begin r.lat = 8'd19; r.ds_occ  = 8'd15; end
      3'd4: begin r.lat = 8'd33; r.mac_occ = 8'd1; r.ds_occ = 8'd29; end
      3'd5: begin r.lat = 8'd4;  r.ls_occ  = 8'd1; end
      3'd6: begin r.lat = 8'd4;  r.ls_occ  = 8'd3; r.quiet = 1'b1; end
      default: begin r.lat = 8'd4; r.mac_occ = 8'd1; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpsb_busy_ctr.sv
module fpsb_busy_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/fpsb_reg_track.sv
module fpsb_reg_track #(
  parameter int NREG = 32,
  parameter int CW   = 6,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] cnt_o [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst)                              cnt_q <= '0;
      else if (wr_en && wr_idx == IW'(g))   cnt_q <= wr_val;
      else if (cnt_q != '0)                 cnt_q <= cnt_q - 1'b1;
    end
    assign cnt_o[g] = cnt_q;
  end
endmodule

// File: rtl/fpsb_hazard.sv
module fpsb_hazard #(
  parameter int NREG = 32,
  parameter int CW   = 6,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [CW-1:0]        reg_cnt [NREG],
  input  logic [IW-1:0]        src0,
  input  logic                 src0_en,
  input  logic [IW-1:0]        src1,
  input  logic                 src1_en,
  input  logic [IW-1:0]        dst,
  input  logic                 dst_en,
  input  fpsb_pkg::op_cost_t   cost,
  input  logic [CW-1:0]        mac_cnt,
  input  logic [CW-1:0]        ds_cnt,
  input  logic [CW-1:0]        ls_cnt,
  output logic                 ok
);
  logic raw0, raw1, waw, st_mac, st_ds, st_ls, st_quiet;

  always_comb begin
    raw0     = src0_en && (reg_cnt[src0] != '0);
    raw1     = src1_en && (reg_cnt[src1] != '0);
    waw      = dst_en  && (reg_cnt[dst]  != '0);
    st_mac   = (cost.mac_occ != '0) && (mac_cnt != '0);
    st_ds    = (cost.ds_occ  != '0) && (ds_cnt  != '0);
    st_ls    = (cost.ls_occ  != '0) && (ls_cnt  != '0);
    st_quiet = cost.quiet && ((mac_cnt != '0) || (ds_cnt != '0));
    ok       = !(raw0 || raw1 || waw || st_mac || st_ds || st_ls || st_quiet);
  end
endmodule

// File: rtl/fp_issue_sb.sv
module fp_issue_sb #(
  parameter int NREG = 32,
  parameter int CW   = 6,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_class,
  input  logic [IW-1:0] in_src0,
  input  logic          in_src0_en,
  input  logic [IW-1:0] in_src1,
  input  logic          in_src1_en,
  input  logic [IW-1:0] in_dst,
  input  logic          in_dst_en,
  output logic          issue_o,
  output logic [2:0]    issue_class_o,
  output logic [IW-1:0] issue_dst_o
);
  import fpsb_pkg::*;

  op_cost_t      cost;
  logic          fire;
  logic [CW-1:0] mac_cnt, ds_cnt, ls_cnt;
  logic [CW-1:0] reg_cnt [NREG];

  assign cost = cost_of(in_class);
  assign fire = in_valid && in_ready;

  // A counter loaded with N-1 frees the resource N cycles after issue.
  fpsb_busy_ctr #(.CW(CW)) u_mac (
    .clk(clk), .rst(rst),
    .load(fire && cost.mac_occ != '0),
    .load_val(CW'(cost.mac_occ - 8'd1)),
    .cnt(mac_cnt)
  );

  fpsb_busy_ctr #(.CW(CW)) u_ds (
    .clk(clk), .rst(rst),
    .load(fire && cost.ds_occ != '0),
    .load_val(CW'(cost.ds_occ - 8'd1)),
    .cnt(ds_cnt)
  );

  fpsb_busy_ctr #(.CW(CW)) u_ls (
    .clk(clk), .rst(rst),
    .load(fire && cost.ls_occ != '0),
    .load_val(CW'(cost.ls_occ - 8'd1)),
    .cnt(ls_cnt)
  );

  fpsb_reg_track #(.NREG(NREG), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(fire && in_dst_en),
    .wr_idx(in_dst),
    .wr_val(CW'(cost.lat - 8'd1)),
    .cnt_o(reg_cnt)
  );

  fpsb_hazard #(.NREG(NREG), .CW(CW)) u_haz (
    .reg_cnt(reg_cnt),
    .src0(in_src0), .src0_en(in_src0_en),
    .src1(in_src1), .src1_en(in_src1_en),
    .dst(in_dst),   .dst_en(in_dst_en),
    .cost(cost),
    .mac_cnt(mac_cnt), .ds_cnt(ds_cnt), .ls_cnt(ls_cnt),
    .ok(in_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_o       <= 1'b0;
      issue_class_o <= '0;
      issue_dst_o   <= '0;
    end else begin
      issue_o <= fire;
      if (fire) begin
        issue_class_o <= in_class;
        issue_dst_o   <= in_dst;
      end
    end
  end
endmodule

// File: rtl/fpsb_checker.sv
module fpsb_checker #(
  parameter int NREG = 32,
  parameter int CW   = 6,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_class,
  input logic [IW-1:0] in_src0,
  input logic          in_src0_en,
  input logic [IW-1:0] in_dst,
  input logic          in_dst_en,
  input logic          issue_o,
  input logic [CW-1:0] mac_cnt,
  input logic [CW-1:0] ds_cnt,
  input logic [CW-1:0] reg_cnt [NREG]
);
  logic fire;
  assign fire = in_valid && in_ready;

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !issue_o);

  assert_no_raw_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && in_src0_en) |-> reg_cnt[in_src0] == '0);

  assert_dmul_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && in_class == 3'd2) |=>
      !(in_valid && in_ready && (in_class <= 3'd2 || in_class == 3'd4)));

  assert_ds_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    (ds_cnt != '0) |=> ds_cnt == $past(ds_cnt) - 1'b1);

  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && in_class == 3'd6) |-> (mac_cnt == '0 && ds_cnt == '0));

  assert_no_waw_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && in_dst_en) |-> reg_cnt[in_dst] == '0);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    fire |=> issue_o);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !issue_o);
endmodule

bind fp_issue_sb fpsb_checker #(.NREG(NREG), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_class(in_class), .in_src0(in_src0), .in_src0_en(in_src0_en),
  .in_dst(in_dst), .in_dst_en(in_dst_en), .issue_o(issue_o),
  .mac_cnt(mac_cnt), .ds_cnt(ds_cnt), .reg_cnt(reg_cnt)
);

// File: tb/fp_issue_sb_tb.sv
module fp_issue_sb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_class = '0;
  logic [IW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
  logic in_src0_en = 1'b0, in_src1_en = 1'b0, in_dst_en = 1'b0;
  logic issue_o;
  logic [2:0] issue_class_o;
  logic [IW-1:0] issue_dst_o;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int         q_exp[$];
  logic [2:0] q_cls[$];
  logic [4:0] q_dst[$];
  string      q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_issue_sb #(.NREG(NREG), .CW(6)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_src0(in_src0), .in_src0_en(in_src0_en),
    .in_src1(in_src1), .in_src1_en(in_src1_en), .in_dst(in_dst),
    .in_dst_en(in_dst_en), .issue_o(issue_o),
    .issue_class_o(issue_class_o), .issue_dst_o(issue_dst_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares every issue pulse with the next expected item.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && issue_o) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R10 unexpected issue", cyc, -1);
        end else begin
          int e; logic [2:0] c; logic [4:0] d; string r;
          e = q_exp.pop_front(); c = q_cls.pop_front();
          d = q_dst.pop_front(); r = q_req.pop_front();
          check(cyc == e, {r, " issue cycle"}, cyc, e);
          check(issue_class_o == c && issue_dst_o == d, {r, " R10 class/dst"},
                {issue_class_o, issue_dst_o}, {c, d});
        end
      end
    end
  end

  // Driver: called at a negedge, returns at the negedge after the handshake.
  task automatic drive(input logic [2:0] c, input logic [4:0] s0, input bit s0e,
                       input logic [4:0] s1, input bit s1e,
                       input logic [4:0] d, input bit de,
                       input int exp, input string req, output int hs);
    in_class = c; in_src0 = s0; in_src0_en = s0e; in_src1 = s1; in_src1_en = s1e;
    in_dst = d; in_dst_en = de; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    hs = cyc + 1;
    q_exp.push_back(exp < 0 ? hs : exp);
    q_cls.push_back(c); q_dst.push_back(d); q_req.push_back(req);
    @(negedge clk);
    in_valid = 1'b0; in_src0_en = 1'b0; in_src1_en = 1'b0; in_dst_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Producer then consumer; consumer must issue exactly gap cycles later.
  task automatic pair(input logic [2:0] pc, input logic [4:0] ps0, input bit ps0e,
                      input logic [4:0] pd, input bit pde,
                      input logic [2:0] cc, input logic [4:0] cs0, input bit cs0e,
                      input logic [4:0] cs1, input bit cs1e,
                      input logic [4:0] cd, input bit cde,
                      input int gap, input string req);
    int hp, hc;
    drive(pc, ps0, ps0e, 5'd0, 1'b0, pd, pde, -1, req, hp);
    drive(cc, cs0, cs0e, cs1, cs1e, cd, cde, hp + gap, req, hc);
    idle(40);
  endtask

  initial begin
    int hs;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    in_class = 3'd6; in_valid = 1'b0; #1;
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(issue_o == 1'b0, "R1 no issue after reset", issue_o, 0);
    in_class = 3'd3; #1;
    check(in_ready == 1'b1, "R1 ready for divide", in_ready, 1);

    // R2: result latencies per class
    pair(3'd0, 0, 0, 5'd1, 1, 3'd5, 5'd1, 1, 0, 0, 0, 0, 4,  "R2 fast");
    pair(3'd1, 0, 0, 5'd2, 1, 3'd5, 5'd2, 1, 0, 0, 0, 0, 8,  "R2 arith");
    pair(3'd2, 0, 0, 5'd3, 1, 3'd5, 5'd3, 1, 0, 0, 0, 0, 9,  "R2 dmul");
    pair(3'd3, 0, 0, 5'd4, 1, 3'd5, 0, 0, 5'd4, 1, 0, 0, 19, "R2 sdiv src1");
    pair(3'd4, 0, 0, 5'd5, 1, 3'd5, 5'd5, 1, 0, 0, 0, 0, 33, "R2 ddiv");
    pair(3'd5, 0, 0, 5'd6, 1, 3'd0, 5'd6, 1, 0, 0, 5'd11, 1, 4, "R2 xfer");
    // R3: MAC occupancy
    pair(3'd0, 0, 0, 5'd12, 1, 3'd0, 0, 0, 0, 0, 5'd13, 1, 1, "R3 fast-fast");
    pair(3'd2, 0, 0, 5'd12, 1, 3'd0, 0, 0, 0, 0, 5'd13, 1, 2, "R3 dmul-fast");
    pair(3'd4, 0, 0, 5'd12, 1, 3'd0, 0, 0, 0, 0, 5'd13, 1, 1, "R3 ddiv-fast");
    pair(3'd4, 0, 0, 5'd12, 1, 3'd2, 0, 0, 0, 0, 5'd14, 1, 1, "R3 ddiv-dmul");
    // R4: DS occupancy
    pair(3'd3, 0, 0, 5'd12, 1, 3'd3, 0, 0, 0, 0, 5'd13, 1, 15, "R4 sdiv-sdiv");
    pair(3'd4, 0, 0, 5'd12, 1, 3'd3, 0, 0, 0, 0, 5'd13, 1, 29, "R4 ddiv-sdiv");
    // R5: LS occupancy
    pair(3'd5, 0, 0, 5'd12, 1, 3'd5, 0, 0, 0, 0, 5'd13, 1, 1, "R5 xfer-xfer");
    pair(3'd6, 0, 0, 5'd0, 0, 3'd5, 0, 0, 0, 0, 5'd13, 1, 3, "R5 flag-xfer");
    // R6: flag transfer waits for MAC and DS idle
    pair(3'd2, 0, 0, 5'd12, 1, 3'd6, 0, 0, 0, 0, 0, 0, 2,  "R6 dmul-flag");
    pair(3'd3, 0, 0, 5'd12, 1, 3'd6, 0, 0, 0, 0, 0, 0, 15, "R6 sdiv-flag");
    pair(3'd4, 0, 0, 5'd12, 1, 3'd6, 0, 0, 0, 0, 0, 0, 29, "R6 ddiv-flag");
    // R7: write-after-write stall
    pair(3'd1, 0, 0, 5'd7, 1, 3'd5, 0, 0, 0, 0, 5'd7, 1, 8, "R7 waw");
    // R8: write-after-read not stalled
    pair(3'd3, 5'd8, 1, 5'd9, 1, 3'd5, 0, 0, 0, 0, 5'd8, 1, 1, "R8 war");
    // R9: disabled fields ignored
    pair(3'd1, 0, 0, 5'd10, 1, 3'd5, 5'd10, 0, 5'd10, 0, 5'd10, 0, 1, "R9 src/dst off");

    // R11: ready reflects counters even with valid low
    drive(3'd3, 0, 0, 0, 0, 5'd15, 1, -1, "R11 setup", hs);
    in_class = 3'd3; in_valid = 1'b0; #1;
    check(in_ready == 1'b0, "R11 ready low while DS busy, valid low", in_ready, 0);
    in_class = 3'd5; #1;
    check(in_ready == 1'b1, "R11 ready high for free LS, valid low", in_ready, 1);
    idle(40);

    check(q_exp.size() == 0, "R10 all expected issues seen", q_exp.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule